// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block is the 32-bit status and control word that sits next to a floating-point datapath. Software reads and writes it through a plain register port. The datapath reads back a two-bit rounding-mode selection. The datapath also reports each operation to this block: it sends a one-cycle start pulse and a five-bit vector of the exceptions that the operation raised.

The word holds three kinds of exception and mode state:

- **Cause field.** Describes only the most recent operation. It is wiped at every operation start.
- **Flag field.** Gathers every exception seen since software last wrote it. It is therefore sticky.
- **Rounding-mode field.** Chooses between round-to-nearest and round-to-zero. The reserved codes are kept as written and are read back unchanged. The datapath treats a reserved code as round-to-nearest.

Bits 21:12 are general control storage that is written and read back. Bits 31:22 do not exist and always read as zero.

The exception vector positions are: bit 0 inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero, bit 4 invalid. The same order is used inside both the cause field and the flag field.

Top module: `fpcsr_top`

## Requirements
- R1: A synchronous active-high reset loads the word 0x00040001. This gives rounding mode 01 and clears both the cause field and the flag field.
- R2: When `wr_en` is high, bits 21:0 of `wr_data` are stored, and `rd_data` shows them from the next cycle. The field positions are: rounding mode in bits 1:0, flag field in bits 6:2, cause field in bits 11:7, and control storage in bits 21:12.
- R3: An `op_start` pulse clears the cause field to zero in the next cycle. This happens even when a write to the cause field occurs in the same cycle.
- R4: Each set bit `exc_vec[i]` sets cause bit 7+i and flag bit 2+i. The bit index i is: 0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid.
- R5: The flag field is sticky. Operation starts and idle cycles leave it unchanged, and only a write can clear its bits.
- R6: `rd_data[31:22]` always reads zero. Writing ones to these bits has no effect.
- R7: When a write and an exception fall in the same cycle, both the cause field and the flag field take the written value ORed with `exc_vec`.
- R8: When `op_start` and an exception fall in the same cycle, the cause field becomes exactly `exc_vec`. The clear applies first and the set applies after it.
- R9: `rnd_mode` presents 00 (round to nearest) for a stored code of 00, 10 or 11, and presents 01 (round to zero) for a stored code of 01. A reserved code still reads back through `rd_data` exactly as it was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value |
| rd_data | output | 32 | Current register word |
| op_start | input | 1 | One-cycle pulse when a floating-point operation begins |
| exc_vec | input | 5 | Exceptions raised by the current operation |
| rnd_mode | output | 2 | Effective rounding mode for the datapath |

## Verification
The bench drives collisions on purpose:

- **Write with exception.** If the write value overwrote the exception, a flag bit would be lost.
- **Start with exception.** A wrong clear order would either drop the new cause bit or leave old cause bits behind.
- **Write with start.** A design that let the write win would leave stale cause bits.

The bench also writes every reserved rounding code and checks two things: a faulty decode would pass a reserved value to the datapath, and faulty storage would change what is read back. A write of all ones checks that bits 31:22 stay zero. Repeated operation starts check that the flag field survives while the cause field resets.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
    localparam int DATA_W    = 32;
    localparam int EXC_W     = 5;
    localparam int RM_W      = 2;
    localparam int AUX_W     = 10;
    localparam int LIVE_W    = RM_W + 2 * EXC_W + AUX_W;
    localparam int PAD_W     = DATA_W - LIVE_W;
    localparam logic [DATA_W-1:0] RESET_VAL = 32'h0004_0001;

    localparam logic [RM_W-1:0] RM_NEAREST = 2'b00;
    localparam logic [RM_W-1:0] RM_ZERO    = 2'b01;

    // Packed MSB first: aux[21:12], cause[11:7], flag[6:2], rm[1:0]
    typedef struct packed {
        logic [AUX_W-1:0] aux;
        logic [EXC_W-1:0] cause;
        logic [EXC_W-1:0] flag;
        logic [RM_W-1:0]  rm;
    } csr_t;
endpackage

// File: rtl/fpcsr_exc_next.sv
module fpcsr_exc_next #(
    parameter int W = 5
) (
    input  logic [W-1:0] hold_q,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic         clr,
    input  logic [W-1:0] set_vec,
    output logic [W-1:0] nxt_d
);
    // Per bit: clear beats write beats hold, then the new event is ORed on top.
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic base;
        always_comb begin
            if (clr)        base = 1'b0;
            else if (wr_en) base = wr_val[i];
            else            base = hold_q[i];
            nxt_d[i] = base | set_vec[i];
        end
    end
endmodule

// File: rtl/fpcsr_rm_decode.sv
module fpcsr_rm_decode
    import fpcsr_pkg::*;
(
    input  logic [RM_W-1:0] rm_q,
    output logic [RM_W-1:0] rm_eff
);
    always_comb begin
        case (rm_q)
            RM_ZERO: rm_eff = RM_ZERO;
            default: rm_eff = RM_NEAREST;
        endcase
    end
endmodule

// File: rtl/fpcsr_top.sv
module fpcsr_top
    import fpcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              op_start,
    input  logic [EXC_W-1:0]  exc_vec,
    output logic [RM_W-1:0]   rnd_mode
);
    csr_t reg_q, reg_d, wr_view;
    logic [EXC_W-1:0] cause_d, flag_d;
    logic unused_hi_bits;

    assign wr_view        = csr_t'(wr_data[LIVE_W-1:0]);
    assign unused_hi_bits = ^wr_data[DATA_W-1:LIVE_W];

    fpcsr_exc_next #(.W(EXC_W)) u_cause (
        .hold_q (reg_q.cause),
        .wr_en  (wr_en),
        .wr_val (wr_view.cause),
        .clr    (op_start),
        .set_vec(exc_vec),
        .nxt_d  (cause_d)
    );

    fpcsr_exc_next #(.W(EXC_W)) u_flag (
        .hold_q (reg_q.flag),
        .wr_en  (wr_en),
        .wr_val (wr_view.flag),
        .clr    (1'b0),
        .set_vec(exc_vec),
        .nxt_d  (flag_d)
    );

    fpcsr_rm_decode u_rm (
        .rm_q  (reg_q.rm),
        .rm_eff(rnd_mode)
    );

    always_comb begin
        reg_d       = reg_q;
        reg_d.cause = cause_d;
        reg_d.flag  = flag_d;
        if (wr_en) begin
            reg_d.rm  = wr_view.rm;
            reg_d.aux = wr_view.aux;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) reg_q <= csr_t'(RESET_VAL[LIVE_W-1:0]);
        else     reg_q <= reg_d;
    end

    assign rd_data = {{PAD_W{1'b0}}, reg_q};

    a_r1_reset_load: assert property (@(posedge clk)
        $past(rst) |-> (rd_data == RESET_VAL));
    a_r3_cause_fresh: assert property (@(posedge clk) disable iff (rst)
        op_start |=> (reg_q.cause == $past(exc_vec)));
    a_r4_exc_recorded: assert property (@(posedge clk) disable iff (rst)
        (|exc_vec) |=> ((reg_q.cause & reg_q.flag & $past(exc_vec)) == $past(exc_vec)));
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ((reg_q.flag & $past(reg_q.flag)) == $past(reg_q.flag)));
    a_r9_rm_legal: assert property (@(posedge clk) disable iff (rst)
        rnd_mode[1] == 1'b0);
    a_r2_rm_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rd_data[RM_W-1:0]));
endmodule

// File: tb/tb_fpcsr_top.sv
module tb_fpcsr_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        op_start;
    logic [4:0]  exc_vec;
    logic [1:0]  rnd_mode;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [31:0] exp_rd_q[$];
    logic [1:0]  exp_rm_q[$];
    string       tag_q[$];

    logic [31:0] model;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpcsr_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .op_start(op_start), .exc_vec(exc_vec),
        .rnd_mode(rnd_mode)
    );

    function automatic logic [1:0] rm_of(input logic [31:0] w);
        return (w[1:0] == 2'b01) ? 2'b01 : 2'b00;
    endfunction

    // Driver: applies one cycle of stimulus and pushes the expected result.
    task automatic step(input logic w, input logic [31:0] wd, input logic op,
                        input logic [4:0] ex, input string tag);
        logic [4:0] cause, flag;
        @(negedge clk);
        wr_en = w; wr_data = wd; op_start = op; exc_vec = ex;
        cause = op ? 5'd0 : (w ? wd[11:7] : model[11:7]);
        flag  = w ? wd[6:2] : model[6:2];
        cause = cause | ex;
        flag  = flag | ex;
        if (w) model[21:12] = wd[21:12];
        if (w) model[1:0]   = wd[1:0];
        model[11:7] = cause;
        model[6:2]  = flag;
        model[31:22] = 10'd0;
        exp_rd_q.push_back(model);
        exp_rm_q.push_back(rm_of(model));
        tag_q.push_back(tag);
    endtask

    // Monitor: compares after each clock edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_rd_q.size() > 0) begin
                logic [31:0] er;
                logic [1:0]  em;
                string       t;
                er = exp_rd_q.pop_front();
                em = exp_rm_q.pop_front();
                t  = tag_q.pop_front();
                total++;
                if (rd_data !== er || rnd_mode !== em) begin
                    bad++;
                    $display("FAIL %s: rd=%h rm=%b expected rd=%h rm=%b",
                             t, rd_data, rnd_mode, er, em);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 0; wr_data = 0; op_start = 0; exc_vec = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if (rd_data !== 32'h0004_0001 || rnd_mode !== 2'b01) begin
            bad++;
            $display("FAIL R1: rd=%h rm=%b expected rd=00040001 rm=01", rd_data, rnd_mode);
        end
        rst = 1'b0;
        model = 32'h0004_0001;

        step(0, 0, 0, 0, "R1 hold after reset");
        step(1, 32'hFFFF_FFFF, 0, 0, "R6 upper bits zero, R9 code 11");
        step(1, 32'h0000_0002, 0, 0, "R9 code 10 stored, nearest out");
        step(1, 32'h0015_A001, 0, 0, "R2 field write readback");
        step(1, 32'h0000_0000, 0, 0, "R9 code 00 nearest");
        step(1, 32'h0000_0F80, 0, 0, "R2 cause written");
        step(0, 0, 1, 0, "R3 op_start clears cause");
        step(0, 0, 0, 5'b00001, "R4 inexact bit");
        step(0, 0, 1, 0, "R5 flag survives op_start");
        step(0, 0, 0, 5'b10000, "R4 invalid bit");
        step(0, 0, 1, 5'b00100, "R8 start with overflow");
        step(0, 0, 0, 0, "R5 idle keeps flag");
        step(1, 32'h0000_0001, 0, 5'b00010, "R7 write with underflow");
        step(1, 32'h0000_0F80, 1, 0, "R3 write with op_start");
        step(1, 32'h0000_0F81, 0, 5'b01000, "R7 write with divzero");
        step(1, 32'h0000_0001, 0, 0, "R5 write clears flag");
        step(0, 0, 1, 5'b11111, "R8 start with all exceptions");

        @(negedge clk);
        wr_en = 0; op_start = 0; exc_vec = 0;
        repeat (3) @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule